// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small processor whose datapath registers all meet on one shared bus. A microprogram counter selects a word from an internal control store; each word drives the register load strobes, the write strobes, one bus-driver enable and a three-bit ALU operation code. Each word also carries a two-bit sequencing code and a target state, from which the block forms the address of the next word.

Four sequencing modes exist: advance by one, jump to the target, jump to the target only when the ALU reports zero, and a dispatch that decodes the instruction register's opcode and function fields into the entry state of a routine. Any instruction that dispatch does not recognise lands in a fallback state that goes straight back to fetch. Microstates that touch memory stall in place while memory reports busy.

The control store holds a fetch sequence and short routines for register add, register subtract, load word, store word and branch-on-zero. These routines give every sequencing mode and both memory directions something to exercise.

Top module: `useq_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `upc` is 0. That is the first fetch state, which asserts `drv_reg`, `ld_ma` and `ld_a`.
- R2: In advance mode, `upc` increments by one on the next clock. Fetch states 0 to 1 and routine steps such as 3 to 4 use this mode.
- R3: In jump mode, `upc` takes the target field whatever `alu_zero` is. The last state of each routine (5, 8, 12, 16, 19, 22, 23) jumps to 0.
- R4: In branch-on-zero mode (state 18), the next state is 20 when `alu_zero` is 1 and 19 when it is 0.
- R5: Dispatch from state 2 uses these codes:
  - opcode 0 with function 0x20 goes to 3;
  - opcode 0 with function 0x22 goes to 6;
  - opcode 0x23 goes to 9, for any function;
  - opcode 0x2B goes to 13;
  - opcode 0x04 goes to 17.
- R6: Every other opcode/function pair dispatches to fallback state 23, whose next state is 0.
- R7: In memory states (1, 12 and 16), `upc` holds while `mem_busy` is 1 and moves on once it is 0. In every other state, `mem_busy` has no effect.
- R8: At most one of `drv_mem`, `drv_reg`, `drv_imm` and `drv_alu` is 1 in any state.
- R9: `alu_op` uses these encodings: 0 pass A, 1 pass B, 2 A+1, 3 A-1, 4 A+4, 5 A-4, 6 A+B, 7 A-B. State 2 drives 4, states 5, 11 and 22 drive 6, and state 8 drives 7.
- R10: Memory strobes by state:
  - state 1 asserts `drv_mem` and `ld_ir`;
  - state 12 asserts `drv_mem` and `reg_wrt`;
  - state 16 asserts `drv_reg` and `mem_wrt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_zero | input | 1 | ALU zero flag |
| ir_opcode | input | 6 | Opcode field of the instruction register |
| ir_func | input | 6 | Function field of the instruction register |
| mem_busy | input | 1 | Memory not ready |
| upc | output | 5 | Current microstate |
| ld_ir | output | 1 | Load instruction register from bus |
| ld_a | output | 1 | Load ALU operand A |
| ld_b | output | 1 | Load ALU operand B |
| ld_ma | output | 1 | Load memory address register |
| reg_wrt | output | 1 | Write register file from bus |
| mem_wrt | output | 1 | Write memory from bus |
| drv_mem | output | 1 | Memory drives bus |
| drv_reg | output | 1 | Register file drives bus |
| drv_imm | output | 1 | Immediate drives bus |
| drv_alu | output | 1 | ALU drives bus |
| alu_op | output | 3 | ALU operation code |

## Verification
The bench sweeps all 4096 opcode/function pairs through fetch and dispatch. A decoder that ignored the function field, or that let an unknown code fall through to a real routine, would send the sequencer to the wrong entry state instead of the fallback. The bench raises `mem_busy` both inside and outside the memory states. A hold applied to the wrong states would either stall non-memory steps or let a load or store finish while memory is still busy. The branch state is driven with both values of the zero flag, so that swapped taken and not-taken paths show up. The bus-driver count is checked on every sampled cycle of the sweep.

// File: rtl/useq_pkg.sv
package useq_pkg;
    parameter int UPC_W = 5;

    typedef logic [UPC_W-1:0] upc_t;

    typedef enum logic [1:0] {
        UB_NEXT = 2'd0,
        UB_JUMP = 2'd1,
        UB_ZERO = 2'd2,
        UB_DISP = 2'd3
    } ubr_e;

    typedef enum logic [2:0] {
        ALU_PASS_A = 3'd0,
        ALU_PASS_B = 3'd1,
        ALU_INC1   = 3'd2,
        ALU_DEC1   = 3'd3,
        ALU_INC4   = 3'd4,
        ALU_DEC4   = 3'd5,
        ALU_ADD    = 3'd6,
        ALU_SUB    = 3'd7
    } aluop_e;

    typedef struct packed {
        logic   ld_ir;
        logic   ld_a;
        logic   ld_b;
        logic   ld_ma;
        logic   reg_wrt;
        logic   mem_wrt;
        logic   drv_mem;
        logic   drv_reg;
        logic   drv_imm;
        logic   drv_alu;
        logic   mem_wait;
        aluop_e op;
        ubr_e   ubr;
        upc_t   nxt;
    } uinst_t;

    localparam upc_t S_FETCH0 = upc_t'(0);
    localparam upc_t S_FETCH1 = upc_t'(1);
    localparam upc_t S_FETCH2 = upc_t'(2);
    localparam upc_t S_ADD    = upc_t'(3);
    localparam upc_t S_SUB    = upc_t'(6);
    localparam upc_t S_LW     = upc_t'(9);
    localparam upc_t S_SW     = upc_t'(13);
    localparam upc_t S_BZ     = upc_t'(17);
    localparam upc_t S_BZ_TKN = upc_t'(20);
    localparam upc_t S_BAD    = upc_t'(23);
endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  upc_t   addr,
    output uinst_t word
);
    always_comb begin
        word     = '0;
        word.op  = ALU_PASS_A;
        word.ubr = UB_JUMP;
        word.nxt = S_FETCH0;
        case (addr)
            // fetch: MA <- PC, A <- PC ; IR <- mem ; PC <- A+4, dispatch
            upc_t'(0):  begin word.drv_reg = 1'b1; word.ld_ma = 1'b1; word.ld_a = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(1):  begin word.drv_mem = 1'b1; word.ld_ir = 1'b1; word.mem_wait = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(2):  begin word.drv_alu = 1'b1; word.op = ALU_INC4; word.reg_wrt = 1'b1; word.ubr = UB_DISP; end
            // register add
            upc_t'(3):  begin word.drv_reg = 1'b1; word.ld_a = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(4):  begin word.drv_reg = 1'b1; word.ld_b = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(5):  begin word.drv_alu = 1'b1; word.op = ALU_ADD; word.reg_wrt = 1'b1; end
            // register subtract
            upc_t'(6):  begin word.drv_reg = 1'b1; word.ld_a = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(7):  begin word.drv_reg = 1'b1; word.ld_b = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(8):  begin word.drv_alu = 1'b1; word.op = ALU_SUB; word.reg_wrt = 1'b1; end
            // load word
            upc_t'(9):  begin word.drv_reg = 1'b1; word.ld_a = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(10): begin word.drv_imm = 1'b1; word.ld_b = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(11): begin word.drv_alu = 1'b1; word.op = ALU_ADD; word.ld_ma = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(12): begin word.drv_mem = 1'b1; word.reg_wrt = 1'b1; word.mem_wait = 1'b1; end
            // store word
            upc_t'(13): begin word.drv_reg = 1'b1; word.ld_a = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(14): begin word.drv_imm = 1'b1; word.ld_b = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(15): begin word.drv_alu = 1'b1; word.op = ALU_ADD; word.ld_ma = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(16): begin word.drv_reg = 1'b1; word.mem_wrt = 1'b1; word.mem_wait = 1'b1; end
            // branch on zero
            upc_t'(17): begin word.drv_reg = 1'b1; word.ld_a = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(18): begin word.op = ALU_PASS_A; word.ubr = UB_ZERO; word.nxt = S_BZ_TKN; end
            upc_t'(19): begin word.ubr = UB_JUMP; end
            upc_t'(20): begin word.drv_reg = 1'b1; word.ld_a = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(21): begin word.drv_imm = 1'b1; word.ld_b = 1'b1; word.ubr = UB_NEXT; end
            upc_t'(22): begin word.drv_alu = 1'b1; word.op = ALU_ADD; word.reg_wrt = 1'b1; end
            // fallback and unused states return to fetch
            default:    begin word.ubr = UB_JUMP; end
        endcase
    end
endmodule

// File: rtl/useq_disp.sv
module useq_disp
    import useq_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int FUNC_W = 6,
    parameter logic [OPC_W-1:0]  OPC_RTYPE = '0,
    parameter logic [OPC_W-1:0]  OPC_LOAD  = OPC_W'(6'h23),
    parameter logic [OPC_W-1:0]  OPC_STORE = OPC_W'(6'h2B),
    parameter logic [OPC_W-1:0]  OPC_BZERO = OPC_W'(6'h04),
    parameter logic [FUNC_W-1:0] FN_ADD    = FUNC_W'(6'h20),
    parameter logic [FUNC_W-1:0] FN_SUB    = FUNC_W'(6'h22)
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FUNC_W-1:0] func,
    output upc_t              target
);
    always_comb begin
        target = S_BAD;
        if (opcode == OPC_RTYPE) begin
            if (func == FN_ADD)      target = S_ADD;
            else if (func == FN_SUB) target = S_SUB;
        end
        else if (opcode == OPC_LOAD)  target = S_LW;
        else if (opcode == OPC_STORE) target = S_SW;
        else if (opcode == OPC_BZERO) target = S_BZ;
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  ubr_e ubr,
    input  upc_t cur,
    input  upc_t field,
    input  upc_t disp,
    input  logic zero,
    output upc_t nxt
);
    always_comb begin
        unique case (ubr)
            UB_NEXT: nxt = cur + upc_t'(1);
            UB_JUMP: nxt = field;
            UB_ZERO: nxt = zero ? field : cur + upc_t'(1);
            UB_DISP: nxt = disp;
            default: nxt = S_FETCH0;
        endcase
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int FUNC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_zero,
    input  logic [OPC_W-1:0]  ir_opcode,
    input  logic [FUNC_W-1:0] ir_func,
    input  logic              mem_busy,
    output logic [UPC_W-1:0]  upc,
    output logic              ld_ir,
    output logic              ld_a,
    output logic              ld_b,
    output logic              ld_ma,
    output logic              reg_wrt,
    output logic              mem_wrt,
    output logic              drv_mem,
    output logic              drv_reg,
    output logic              drv_imm,
    output logic              drv_alu,
    output logic [2:0]        alu_op
);
    typedef struct packed {
        upc_t upc;
    } st_t;

    st_t    st_d, st_q;
    uinst_t uw;
    upc_t   disp_tgt;
    upc_t   upc_nx;
    logic   hold;

    useq_rom u_rom (.addr(st_q.upc), .word(uw));

    useq_disp #(.OPC_W(OPC_W), .FUNC_W(FUNC_W)) u_disp (
        .opcode(ir_opcode), .func(ir_func), .target(disp_tgt)
    );

    useq_next u_next (
        .ubr(uw.ubr), .cur(st_q.upc), .field(uw.nxt),
        .disp(disp_tgt), .zero(alu_zero), .nxt(upc_nx)
    );

    assign hold = uw.mem_wait & mem_busy;

    always_comb begin
        st_d = st_q;
        if (!hold) st_d.upc = upc_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{upc: S_FETCH0};
        else        st_q <= st_d;
    end

    assign upc     = st_q.upc;
    assign ld_ir   = uw.ld_ir;
    assign ld_a    = uw.ld_a;
    assign ld_b    = uw.ld_b;
    assign ld_ma   = uw.ld_ma;
    assign reg_wrt = uw.reg_wrt;
    assign mem_wrt = uw.mem_wrt;
    assign drv_mem = uw.drv_mem;
    assign drv_reg = uw.drv_reg;
    assign drv_imm = uw.drv_imm;
    assign drv_alu = uw.drv_alu;
    assign alu_op  = uw.op;

    AST_RESET_FETCH: assert property (@(posedge clk)
        !rst_n |=> (st_q.upc == S_FETCH0));  // R1

    AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.ubr == UB_NEXT && !hold) |=> (st_q.upc == upc_t'($past(st_q.upc) + 1'b1)));  // R2

    AST_SEQ_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.ubr == UB_JUMP && !hold) |=> (st_q.upc == $past(uw.nxt)));  // R3

    AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.ubr == UB_ZERO && alu_zero) |=> (st_q.upc == $past(uw.nxt)));  // R4

    AST_ZERO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.ubr == UB_ZERO && !alu_zero) |=> (st_q.upc == upc_t'($past(st_q.upc) + 1'b1)));  // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.mem_wait && mem_busy) |=> $stable(st_q.upc));  // R7

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_mem, drv_reg, drv_imm, drv_alu}));  // R8
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_zero = 1'b0;
    logic [5:0] ir_opcode = '0;
    logic [5:0] ir_func = '0;
    logic       mem_busy = 1'b0;
    logic [4:0] upc;
    logic       ld_ir, ld_a, ld_b, ld_ma, reg_wrt, mem_wrt;
    logic       drv_mem, drv_reg, drv_imm, drv_alu;
    logic [2:0] alu_op;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_top dut (
        .clk(clk), .rst_n(rst_n), .alu_zero(alu_zero), .ir_opcode(ir_opcode),
        .ir_func(ir_func), .mem_busy(mem_busy), .upc(upc), .ld_ir(ld_ir),
        .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma), .reg_wrt(reg_wrt),
        .mem_wrt(mem_wrt), .drv_mem(drv_mem), .drv_reg(drv_reg),
        .drv_imm(drv_imm), .drv_alu(drv_alu), .alu_op(alu_op)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("R8 driver count", ($countones({drv_mem, drv_reg, drv_imm, drv_alu}) <= 1) ? 1 : 0, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mem_busy = 1'b0;
        alu_zero = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 upc in reset", int'(upc), 0);
        rst_n = 1'b1;
    endtask

    function automatic int exp_disp(input int op, input int fn);
        if (op == 0 && fn == 'h20) return 3;
        if (op == 0 && fn == 'h22) return 6;
        if (op == 'h23) return 9;
        if (op == 'h2B) return 13;
        if (op == 'h04) return 17;
        return 23;
    endfunction

    // run fetch from state 0 with the given instruction, ending in the dispatch target
    task automatic fetch(input int op, input int fn);
        ir_opcode = 6'(op);
        ir_func   = 6'(fn);
        tick(); tick(); tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 first cycle after release
        chk("R1 upc after reset", int'(upc), 0);
        chk("R1 drv_reg", int'(drv_reg), 1);
        chk("R1 ld_ma", int'(ld_ma), 1);
        chk("R1 ld_a", int'(ld_a), 1);

        // R7 busy ignored in non-memory state 0
        mem_busy = 1'b1;
        tick();
        chk("R7 busy ignored in state 0", int'(upc), 1);
        chk("R10 state1 drv_mem", int'(drv_mem), 1);
        chk("R10 state1 ld_ir", int'(ld_ir), 1);
        tick();
        chk("R7 hold in state 1", int'(upc), 1);
        tick();
        chk("R7 hold in state 1 again", int'(upc), 1);
        mem_busy = 1'b0;
        ir_opcode = 6'h00; ir_func = 6'h20;
        tick();
        chk("R2 advance 1->2", int'(upc), 2);
        chk("R9 alu_op inc4", int'(alu_op), 4);
        tick();
        chk("R5 dispatch add", int'(upc), 3);
        mem_busy = 1'b1;
        tick();
        chk("R2/R7 advance 3->4 with busy", int'(upc), 4);
        mem_busy = 1'b0;
        tick();
        chk("R2 advance 4->5", int'(upc), 5);
        chk("R9 alu_op add", int'(alu_op), 6);
        alu_zero = 1'b1;
        tick();
        chk("R3 jump 5->0", int'(upc), 0);
        alu_zero = 1'b0;

        // subtract routine
        fetch(0, 'h22);
        chk("R5 dispatch sub", int'(upc), 6);
        tick(); tick();
        chk("R9 alu_op sub", int'(alu_op), 7);
        tick();
        chk("R3 jump 8->0", int'(upc), 0);

        // load with busy hold at state 12
        fetch('h23, 'h3F);
        chk("R5 dispatch load", int'(upc), 9);
        tick(); tick();
        chk("R9 alu_op address add", int'(alu_op), 6);
        tick();
        chk("R2 reach 12", int'(upc), 12);
        chk("R10 state12 drv_mem", int'(drv_mem), 1);
        chk("R10 state12 reg_wrt", int'(reg_wrt), 1);
        mem_busy = 1'b1;
        tick(); tick();
        chk("R7 hold in state 12", int'(upc), 12);
        mem_busy = 1'b0;
        tick();
        chk("R3 jump 12->0", int'(upc), 0);

        // store with busy hold at state 16
        fetch('h2B, 0);
        chk("R5 dispatch store", int'(upc), 13);
        tick(); tick(); tick();
        chk("R10 state16 mem_wrt", int'(mem_wrt), 1);
        chk("R10 state16 drv_reg", int'(drv_reg), 1);
        mem_busy = 1'b1;
        tick();
        chk("R7 hold in state 16", int'(upc), 16);
        mem_busy = 1'b0;
        tick();
        chk("R3 jump 16->0", int'(upc), 0);

        // branch taken and not taken
        for (int z = 0; z < 2; z++) begin
            fetch('h04, 0);
            chk("R5 dispatch bzero", int'(upc), 17);
            tick();
            chk("R2 advance 17->18", int'(upc), 18);
            alu_zero = z[0];
            tick();
            alu_zero = 1'b0;
            if (z == 1) begin
                chk("R4 zero taken", int'(upc), 20);
                tick(); tick();
                chk("R9 alu_op branch add", int'(alu_op), 6);
                tick();
                chk("R3 jump 22->0", int'(upc), 0);
            end else begin
                chk("R4 zero not taken", int'(upc), 19);
                alu_zero = 1'b1;
                tick();
                alu_zero = 1'b0;
                chk("R3 jump 19->0 ignores zero", int'(upc), 0);
            end
        end

        // exhaustive dispatch sweep
        for (int op = 0; op < 64; op++) begin
            for (int fn = 0; fn < 64; fn++) begin
                do_reset();
                fetch(op, fn);
                chk("R5/R6 dispatch sweep", int'(upc), exp_disp(op, fn));
                if (exp_disp(op, fn) == 23) begin
                    tick();
                    chk("R6 fallback returns to fetch", int'(upc), 0);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule